// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small single-accumulator processor that runs each instruction as a chain of register transfers. It has a program counter, a memory address register, a memory data register, a current instruction register, an 8-bit accumulator, an 8-bit index register and a 4-bit status register. The only path to memory is one synchronous, word-addressed port. The address bus is always driven from the memory address register, and separate read-enable and write-enable strobes go with it. Read data comes back one clock after the read strobe.

Each instruction word is 16 bits. The top byte selects the operation and the bottom byte is the operand. There are four ways to load the accumulator: the operand value itself, the word at the operand address, the word at an address that is itself read from memory, and the word at the operand plus the index register. There is also an instruction that loads the index register, an add from memory that sets the flags, a store, a return from interrupt, and a halt. A single interrupt request line is looked at once per instruction, after execution finishes. A taken request saves the program counter, jumps to a fixed vector and masks any further requests until the return instruction.

The controller steps through these named states:

- **Fetch:** FETCH_MAR, FETCH_INC, FETCH_MDR, FETCH_CIR, then DECODE.
- **Execute:** EXEC_IMM, EXEC_LDR, EXEC_ADR, EXEC_RD, EXEC_MDR, IND_ADR, IND_RD, IND_MDR, EXEC_LOAD, EXEC_ADD, EXEC_STO, EXEC_RTI.
- **End of instruction:** IRQ_CHK, which leads back to FETCH_MAR.
- **Stop:** HALT.

The transitions are:

- DECODE goes to EXEC_IMM, EXEC_LDR, EXEC_ADR, EXEC_RTI or HALT, depending on the opcode. It goes straight to IRQ_CHK for an opcode it does not know.
- EXEC_ADR goes to EXEC_STO for a store. For every other opcode it goes to EXEC_RD.
- EXEC_MDR goes to IND_ADR for an indirect load, to EXEC_ADD for an add, and to EXEC_LOAD otherwise.
- IND_MDR goes to EXEC_LOAD.
- Every execute state that finishes an instruction goes to IRQ_CHK.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is low, the program counter, accumulator, index register, status register and instruction register are all zero, and no memory strobe is asserted. After reset is released, the first fetch reads address 0.
- R2: Every fetch presents the program counter on the address bus, asserts the read strobe for one cycle, and increments the program counter by exactly one.
- R3: An instruction word holds the opcode in bits 15:8 and the operand in bits 7:0. Opcode 0x01 loads the operand value itself into the accumulator, so word 0x0121 loads 33.
- R4: Opcode 0x02 loads the accumulator from bits 7:0 of the memory word at the operand address.
- R5: Opcode 0x03 reads the word at the operand address and uses its low byte as a second address. It then loads the accumulator from that second address. With memory 55 holding 52 and memory 52 holding 135, the accumulator ends at 135.
- R6: Opcode 0x05 loads the operand value into the index register. Opcode 0x04 loads the accumulator from address operand + index, taken modulo 256. With an index of 2 and operand 51, the load reads address 53.
- R7: Opcode 0x06 adds the low byte of the memory word at the operand address to the accumulator. It writes the 8-bit sum to the accumulator and updates three status bits: bit 0 is the carry out, bit 1 is signed overflow, and bit 2 is the sum's bit 7. No other instruction changes status bits 2:0.
- R8: Opcode 0x07 writes the accumulator, zero-extended to 16 bits, to the operand address. The write strobe is asserted for exactly one cycle.
- R9: Any opcode outside 0x01 to 0x08 and 0xFF changes nothing except advancing the program counter.
- R10: The interrupt request is sampled only in the end-of-instruction state. If it is high while status bit 3 is clear, the core saves the program counter, loads 0xF0 into the program counter and sets status bit 3.
- R11: While status bit 3 is set, interrupt requests are ignored. Opcode 0x08 restores the saved program counter and clears status bit 3.
- R12: Opcode 0xFF stops the core for good. After it, the halted output stays high, the program counter is frozen, no memory strobe is asserted and no further instruction completes.
- R13: The read and write strobes are never asserted in the same cycle. Read data is taken exactly one cycle after its read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Memory word address, always the memory address register |
| mem_re | output | 1 | Read strobe; data is returned on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (zero-extended accumulator) |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_re |
| irq | input | 1 | Interrupt request, level sensitive |
| halted | output | 1 | High once a halt instruction has executed |
| instr_done | output | 1 | High for one cycle at the end of every completed instruction |
| pc_out | output | 8 | Program counter |
| acc_out | output | 8 | Accumulator |
| ix_out | output | 8 | Index register |
| status_out | output | 4 | Status: bit 0 carry, bit 1 overflow, bit 2 negative, bit 3 interrupt mask |

## Verification
The assertions assume that the memory behaves as a synchronous array: whatever it returns the cycle after a read strobe is what the core captures. They also assume that the interrupt line is a clean level, sampled on the clock. The bench's memory model follows exactly that one-cycle read contract. It changes the interrupt line only on falling clock edges, so the line can never move near the sampling edge. The interrupt is raised during the end-of-instruction state of a known instruction. It is kept high across the handler to exercise masking, and it is dropped before the return instruction executes, so the outcome never depends on timing inside an instruction.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OP_LDM = 8'h01;
    localparam logic [OPC_W-1:0] OP_LDD = 8'h02;
    localparam logic [OPC_W-1:0] OP_LDI = 8'h03;
    localparam logic [OPC_W-1:0] OP_LDX = 8'h04;
    localparam logic [OPC_W-1:0] OP_LDR = 8'h05;
    localparam logic [OPC_W-1:0] OP_ADD = 8'h06;
    localparam logic [OPC_W-1:0] OP_STO = 8'h07;
    localparam logic [OPC_W-1:0] OP_RTI = 8'h08;
    localparam logic [OPC_W-1:0] OP_HLT = 8'hFF;

    localparam int ST_C    = 0;
    localparam int ST_V    = 1;
    localparam int ST_N    = 2;
    localparam int ST_MASK = 3;
    localparam int ST_W    = 4;

    typedef enum logic [4:0] {
        S_FETCH_MAR,
        S_FETCH_INC,
        S_FETCH_MDR,
        S_FETCH_CIR,
        S_DECODE,
        S_EXEC_IMM,
        S_EXEC_LDR,
        S_EXEC_ADR,
        S_EXEC_RD,
        S_EXEC_MDR,
        S_IND_ADR,
        S_IND_RD,
        S_IND_MDR,
        S_EXEC_LOAD,
        S_EXEC_ADD,
        S_EXEC_STO,
        S_EXEC_RTI,
        S_IRQ_CHK,
        S_HALT
    } cpu_state_e;

    typedef enum logic [1:0] {
        MAR_FROM_PC,
        MAR_FROM_OPND,
        MAR_FROM_IDX,
        MAR_FROM_MDR
    } mar_src_e;

    typedef enum logic [1:0] {
        ACC_FROM_OPND,
        ACC_FROM_MDR,
        ACC_FROM_SUM
    } acc_src_e;

    typedef struct packed {
        logic     mar_we;
        mar_src_e mar_src;
        logic     pc_inc;
        logic     pc_vec;
        logic     pc_ret;
        logic     mdr_we;
        logic     cir_we;
        logic     acc_we;
        acc_src_e acc_src;
        logic     ix_we;
        logic     flags_we;
        logic     mask_set;
        logic     mask_clr;
        logic     mem_re;
        logic     mem_we;
    } cpu_ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf,
    output logic              neg
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    always_comb begin
        wide  = {1'b0, op_a} + {1'b0, op_b};
        sum   = wide[DATA_W-1:0];
        carry = wide[DATA_W];
        // signed overflow: operands share a sign that the result does not
        ovf   = (op_a[MSB] == op_b[MSB]) && (wide[MSB] != op_a[MSB]);
        neg   = wide[MSB];
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             irq,
    input  logic             irq_masked,
    output cpu_state_e       state,
    output cpu_ctl_t         ctl
);

    cpu_state_e state_q;
    cpu_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FETCH_MAR;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH_MAR: state_d = S_FETCH_INC;
            S_FETCH_INC: state_d = S_FETCH_MDR;
            S_FETCH_MDR: state_d = S_FETCH_CIR;
            S_FETCH_CIR: state_d = S_DECODE;
            S_DECODE: begin
                unique case (opcode)
                    OP_LDM:  state_d = S_EXEC_IMM;
                    OP_LDR:  state_d = S_EXEC_LDR;
                    OP_LDD,
                    OP_LDI,
                    OP_LDX,
                    OP_ADD,
                    OP_STO:  state_d = S_EXEC_ADR;
                    OP_RTI:  state_d = S_EXEC_RTI;
                    OP_HLT:  state_d = S_HALT;
                    default: state_d = S_IRQ_CHK;
                endcase
            end
            S_EXEC_IMM:  state_d = S_IRQ_CHK;
            S_EXEC_LDR:  state_d = S_IRQ_CHK;
            S_EXEC_ADR:  state_d = (opcode == OP_STO) ? S_EXEC_STO : S_EXEC_RD;
            S_EXEC_RD:   state_d = S_EXEC_MDR;
            S_EXEC_MDR: begin
                if (opcode == OP_LDI) begin
                    state_d = S_IND_ADR;
                end else if (opcode == OP_ADD) begin
                    state_d = S_EXEC_ADD;
                end else begin
                    state_d = S_EXEC_LOAD;
                end
            end
            S_IND_ADR:   state_d = S_IND_RD;
            S_IND_RD:    state_d = S_IND_MDR;
            S_IND_MDR:   state_d = S_EXEC_LOAD;
            S_EXEC_LOAD: state_d = S_IRQ_CHK;
            S_EXEC_ADD:  state_d = S_IRQ_CHK;
            S_EXEC_STO:  state_d = S_IRQ_CHK;
            S_EXEC_RTI:  state_d = S_IRQ_CHK;
            S_IRQ_CHK:   state_d = S_FETCH_MAR;
            S_HALT:      state_d = S_HALT;
            default:     state_d = S_FETCH_MAR;
        endcase
    end

    // outputs
    always_comb begin
        ctl = '0;
        unique case (state_q)
            S_FETCH_MAR: begin
                ctl.mar_we  = 1'b1;
                ctl.mar_src = MAR_FROM_PC;
            end
            S_FETCH_INC: begin
                ctl.pc_inc = 1'b1;
                ctl.mem_re = 1'b1;
            end
            S_FETCH_MDR: ctl.mdr_we = 1'b1;
            S_FETCH_CIR: ctl.cir_we = 1'b1;
            S_DECODE:    ctl = '0;
            S_EXEC_IMM: begin
                ctl.acc_we  = 1'b1;
                ctl.acc_src = ACC_FROM_OPND;
            end
            S_EXEC_LDR:  ctl.ix_we = 1'b1;
            S_EXEC_ADR: begin
                ctl.mar_we  = 1'b1;
                ctl.mar_src = (opcode == OP_LDX) ? MAR_FROM_IDX : MAR_FROM_OPND;
            end
            S_EXEC_RD:   ctl.mem_re = 1'b1;
            S_EXEC_MDR:  ctl.mdr_we = 1'b1;
            S_IND_ADR: begin
                ctl.mar_we  = 1'b1;
                ctl.mar_src = MAR_FROM_MDR;
            end
            S_IND_RD:    ctl.mem_re = 1'b1;
            S_IND_MDR:   ctl.mdr_we = 1'b1;
            S_EXEC_LOAD: begin
                ctl.acc_we  = 1'b1;
                ctl.acc_src = ACC_FROM_MDR;
            end
            S_EXEC_ADD: begin
                ctl.acc_we   = 1'b1;
                ctl.acc_src  = ACC_FROM_SUM;
                ctl.flags_we = 1'b1;
            end
            S_EXEC_STO:  ctl.mem_we = 1'b1;
            S_EXEC_RTI: begin
                ctl.pc_ret   = 1'b1;
                ctl.mask_clr = 1'b1;
            end
            S_IRQ_CHK: begin
                if (irq && !irq_masked) begin
                    ctl.pc_vec   = 1'b1;
                    ctl.mask_set = 1'b1;
                end
            end
            S_HALT:      ctl = '0;
            default:     ctl = '0;
        endcase
    end

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 8,
    parameter logic [ADDR_W-1:0] VECTOR = 8'hF0,
    localparam int             WORD_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cpu_ctl_t          ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] alu_sum,
    input  logic              alu_c,
    input  logic              alu_v,
    input  logic              alu_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [OPC_W-1:0]  opcode,
    output logic [DATA_W-1:0] mdr_data,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] ix,
    output logic [ADDR_W-1:0] pc,
    output logic [ST_W-1:0]   status,
    output logic              irq_masked
);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_shadow_q;
    logic [ADDR_W-1:0] mar_q;
    logic [WORD_W-1:0] mdr_q;
    logic [WORD_W-1:0] cir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] ix_q;
    logic [ST_W-1:0]   st_q;

    logic [ADDR_W-1:0] operand;
    logic [ADDR_W-1:0] idx_addr;

    assign operand  = cir_q[ADDR_W-1:0];
    assign idx_addr = operand + ADDR_W'(ix_q);

    // program counter with interrupt shadow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q        <= '0;
            pc_shadow_q <= '0;
        end else if (ctl.pc_vec) begin
            pc_shadow_q <= pc_q;
            pc_q        <= VECTOR;
        end else if (ctl.pc_ret) begin
            pc_q <= pc_shadow_q;
        end else if (ctl.pc_inc) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // memory address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (ctl.mar_we) begin
            unique case (ctl.mar_src)
                MAR_FROM_PC:   mar_q <= pc_q;
                MAR_FROM_OPND: mar_q <= operand;
                MAR_FROM_IDX:  mar_q <= idx_addr;
                MAR_FROM_MDR:  mar_q <= mdr_q[ADDR_W-1:0];
                default:       mar_q <= pc_q;
            endcase
        end
    end

    // memory data and current instruction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
            cir_q <= '0;
        end else begin
            if (ctl.mdr_we) begin
                mdr_q <= mem_rdata;
            end
            if (ctl.cir_we) begin
                cir_q <= mdr_q;
            end
        end
    end

    // accumulator and index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ix_q  <= '0;
        end else begin
            if (ctl.acc_we) begin
                unique case (ctl.acc_src)
                    ACC_FROM_OPND: acc_q <= DATA_W'(operand);
                    ACC_FROM_MDR:  acc_q <= mdr_q[DATA_W-1:0];
                    ACC_FROM_SUM:  acc_q <= alu_sum;
                    default:       acc_q <= acc_q;
                endcase
            end
            if (ctl.ix_we) begin
                ix_q <= DATA_W'(operand);
            end
        end
    end

    // status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            if (ctl.flags_we) begin
                st_q[ST_C] <= alu_c;
                st_q[ST_V] <= alu_v;
                st_q[ST_N] <= alu_n;
            end
            if (ctl.mask_set) begin
                st_q[ST_MASK] <= 1'b1;
            end else if (ctl.mask_clr) begin
                st_q[ST_MASK] <= 1'b0;
            end
        end
    end

    assign mem_addr   = mar_q;
    assign mem_wdata  = WORD_W'(acc_q);
    assign opcode     = cir_q[WORD_W-1:ADDR_W];
    assign mdr_data   = mdr_q[DATA_W-1:0];
    assign acc        = acc_q;
    assign ix         = ix_q;
    assign pc         = pc_q;
    assign status     = st_q;
    assign irq_masked = st_q[ST_MASK];

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 8,
    parameter logic [ADDR_W-1:0] VECTOR = 8'hF0,
    localparam int             WORD_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              irq,
    output logic              halted,
    output logic              instr_done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] ix_out,
    output logic [ST_W-1:0]   status_out
);

    cpu_state_e        fsm_state;
    cpu_ctl_t          ctl;
    logic [OPC_W-1:0]  opcode;
    logic              irq_masked;
    logic [DATA_W-1:0] mdr_data;
    logic [DATA_W-1:0] alu_sum;
    logic              alu_c;
    logic              alu_v;
    logic              alu_n;

    acc_cpu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode     (opcode),
        .irq        (irq),
        .irq_masked (irq_masked),
        .state      (fsm_state),
        .ctl        (ctl)
    );

    acc_cpu_dp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .VECTOR (VECTOR)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .mem_rdata  (mem_rdata),
        .alu_sum    (alu_sum),
        .alu_c      (alu_c),
        .alu_v      (alu_v),
        .alu_n      (alu_n),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .opcode     (opcode),
        .mdr_data   (mdr_data),
        .acc        (acc_out),
        .ix         (ix_out),
        .pc         (pc_out),
        .status     (status_out),
        .irq_masked (irq_masked)
    );

    acc_cpu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op_a  (acc_out),
        .op_b  (mdr_data),
        .sum   (alu_sum),
        .carry (alu_c),
        .ovf   (alu_v),
        .neg   (alu_n)
    );

    assign mem_re     = ctl.mem_re;
    assign mem_we     = ctl.mem_we;
    assign instr_done = (fsm_state == S_IRQ_CHK);
    assign halted     = (fsm_state == S_HALT);

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter logic [ADDR_W-1:0] VECTOR = 8'hF0
) (
    input logic              clk,
    input logic              rst_n,
    input cpu_state_e        state,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_re,
    input logic              mem_we,
    input logic              irq,
    input logic [ST_W-1:0]   status,
    input logic              halted
);

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH_INC) |-> (mem_re && mem_addr == pc)); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH_INC) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R2

    AST_FLAGS_ONLY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_EXEC_ADD) |=> (status[ST_N:ST_C] == $past(status[ST_N:ST_C]))); // R7

    AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R8

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IRQ_CHK && irq && !status[ST_MASK]) |=> (pc == VECTOR && status[ST_MASK])); // R10

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IRQ_CHK && status[ST_MASK]) |=> (pc == $past(pc) && status[ST_MASK])); // R11

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_re && !mem_we && $stable(pc))); // R12

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R13

endmodule

bind acc_cpu_core acc_cpu_chk #(
    .ADDR_W (ADDR_W),
    .VECTOR (VECTOR)
) u_acc_cpu_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (fsm_state),
    .pc       (pc_out),
    .mem_addr (mem_addr),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .irq      (irq),
    .status   (status_out),
    .halted   (halted)
);

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  mem_addr;
    logic        mem_re;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        irq;
    logic        halted;
    logic        instr_done;
    logic [7:0]  pc_out;
    logic [7:0]  acc_out;
    logic [7:0]  ix_out;
    logic [3:0]  status_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    bit irq_fired = 0;

    typedef struct {
        logic [7:0] acc;
        logic [7:0] ix;
        logic [7:0] pc;
        logic [3:0] st;
        string      tag;
    } exp_t;

    exp_t sb[$];

    logic [15:0] mem [256];

    always #5 clk = ~clk;

    // synchronous memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    acc_cpu_core i_acc_cpu_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_addr   (mem_addr),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .irq        (irq),
        .halted     (halted),
        .instr_done (instr_done),
        .pc_out     (pc_out),
        .acc_out    (acc_out),
        .ix_out     (ix_out),
        .status_out (status_out)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [7:0] x, input logic [7:0] p,
                        input logic [3:0] s, input string tag);
        exp_t e;
        e.acc = a; e.ix = x; e.pc = p; e.st = s; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // monitor: compares each completed instruction against the scoreboard
    initial begin
        irq = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && instr_done === 1'b1) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R12", "unexpected completion pc", {24'd0, pc_out}, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(acc_out == e.acc, e.tag, "acc", {24'd0, acc_out}, {24'd0, e.acc});
                    check(ix_out == e.ix && pc_out == e.pc && status_out == e.st, e.tag,
                          "ix/pc/status", {12'd0, ix_out, pc_out, status_out},
                          {12'd0, e.ix, e.pc, e.st});
                end
                // interrupt raised at end of the instruction at 12, dropped before return
                if (pc_out == 8'd13 && !irq_fired) begin
                    irq = 1'b1;
                    irq_fired = 1'b1;
                end
                if (pc_out == 8'hF2) irq = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R12 watchdog: actual 0x0 expected 0x1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] pc_hold;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[51] = 16'd54;  mem[52] = 16'd135; mem[53] = 16'd172;
        mem[54] = 16'd201; mem[55] = 16'd52;  mem[56] = 16'd89;
        mem[57] = 16'd50;  mem[58] = 16'd0;
        mem[0]  = 16'h0121; // load immediate 33
        mem[1]  = 16'h0238; // direct 56
        mem[2]  = 16'h0337; // indirect 55
        mem[3]  = 16'h0502; // index = 2
        mem[4]  = 16'h0433; // indexed 51
        mem[5]  = 16'h0638; // add [56]
        mem[6]  = 16'h0164; // load immediate 100
        mem[7]  = 16'h0639; // add [57]
        mem[8]  = 16'h073C; // store 60
        mem[9]  = 16'h023C; // direct 60
        mem[10] = 16'h0900; // unknown opcode
        mem[11] = 16'h0100; // load immediate 0
        mem[12] = 16'h063A; // add [58]
        mem[13] = 16'h0109; // load immediate 9
        mem[14] = 16'hFF00; // halt
        mem[15] = 16'h0177; // must never execute
        mem[8'hF0] = 16'h0107;
        mem[8'hF1] = 16'h0108;
        mem[8'hF2] = 16'h0800;

        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(pc_out == 8'd0 && acc_out == 8'd0 && ix_out == 8'd0, "R1", "pc/acc/ix",
              {8'd0, pc_out, acc_out, ix_out}, 32'd0);
        check(status_out == 4'd0 && !halted && !instr_done && !mem_re && !mem_we, "R1",
              "status/strobes", {27'd0, status_out, mem_re | mem_we}, 32'd0);

        push(8'd33,  8'd0, 8'd1,  4'b0000, "R3");
        push(8'd89,  8'd0, 8'd2,  4'b0000, "R4");
        push(8'd135, 8'd0, 8'd3,  4'b0000, "R5");
        push(8'd135, 8'd2, 8'd4,  4'b0000, "R6");
        push(8'd172, 8'd2, 8'd5,  4'b0000, "R6");
        push(8'd5,   8'd2, 8'd6,  4'b0001, "R7");  // carry only
        push(8'd100, 8'd2, 8'd7,  4'b0001, "R7");  // load leaves flags
        push(8'd150, 8'd2, 8'd8,  4'b0110, "R7");  // overflow + negative
        push(8'd150, 8'd2, 8'd9,  4'b0110, "R8");
        push(8'd150, 8'd2, 8'd10, 4'b0110, "R8");  // reads back the stored word
        push(8'd150, 8'd2, 8'd11, 4'b0110, "R9");
        push(8'd0,   8'd2, 8'd12, 4'b0110, "R3");
        push(8'd0,   8'd2, 8'd13, 4'b0000, "R7");
        push(8'd7,   8'd2, 8'hF1, 4'b1000, "R10");
        push(8'd8,   8'd2, 8'hF2, 4'b1000, "R11");
        push(8'd8,   8'd2, 8'd13, 4'b0000, "R11");
        push(8'd9,   8'd2, 8'd14, 4'b0000, "R2");

        rst_n = 1'b1;
        while (halted !== 1'b1) @(negedge clk);
        pc_hold = pc_out;
        repeat (20) @(negedge clk);
        check(halted === 1'b1 && !mem_re && !mem_we, "R12", "halted/strobes",
              {30'd0, halted, mem_re | mem_we}, 32'd2);
        check(pc_out == pc_hold && pc_out == 8'd15, "R12", "frozen pc",
              {24'd0, pc_out}, 32'd15);
        check(acc_out == 8'd9, "R12", "acc after halt", {24'd0, acc_out}, 32'd9);
        check(mem[60] == 16'h0096, "R8", "stored word", {16'd0, mem[60]}, 32'h96);
        check(sb.size() == 0, "R10", "pending expectations", sb.size(), 32'd0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule